// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the slave end of a two-wire serial management link. A station manager drives a slow management clock and a bidirectional data line; the slave samples the data line on each rising edge of the management clock, recognises a start condition, collects the operation code and the two address fields, and then either returns a 16-bit register value or accepts a 16-bit value to be stored. The register file is not part of the block. It sits behind a simple port: a one-cycle strobe carrying a register number, a write flag and write data, plus a read-data bus that the slave samples when it issues a read.

Both management wires are brought into the system clock domain through synchronisers, and a rising-edge detector on the synchronised clock produces the bit tick that advances the frame decoder. During a read the slave drives the line through an output enable. Only one physical device is modelled, so the device-address field of every frame is accepted and thrown away.

Top module: `mgmt_frame_slave`

## Requirements
- R1: While idle, sampled 1s leave the slave idle; a sampled 0 moves it to a start-wait state, in which further 0s are absorbed and the first sampled 1 begins header collection.
- R2: The header is 12 bits, most significant first: a 2-bit opcode, a 5-bit device address, a 5-bit register number. Opcode 2'b10 is a read and 2'b01 is a write.
- R3: The device-address bits are discarded; frames for every device address are acted on identically.
- R4: For a read, a one-cycle strobe with `reg_write` = 0 and `reg_addr` equal to the register number is issued after the 12th header bit, and `reg_rdata` is captured in the following clock cycle.
- R5: After a read header the slave drives the line to 0 with `mdio_oe` = 1 for one management-clock period, then drives the 16 captured bits most significant first, each bit changing shortly after a management-clock rising edge, and then returns to idle.
- R6: After a write header the next two sampled bits are ignored whatever their value; the following 16 bits are shifted in most significant first, and after the 16th a one-cycle strobe with `reg_write` = 1, the saved register number and the assembled word is issued.
- R7: Opcodes 2'b00 and 2'b11 produce no strobe and no drive; the slave returns to idle and decodes the next frame normally.
- R8: `mdio_oe` is 1 only during the read turnaround bit and the 16 read-data bits, and `mdio_out` is 0 whenever `mdio_oe` is 0.
- R9: After reset the slave is idle, `mdio_oe` and `mdio_out` are 0 and no strobe is issued.
- R10: Every register-port strobe lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_in | input | 1 | Management clock from the station manager (asynchronous) |
| mdio_in | input | 1 | Management data line as seen at the pad |
| mdio_out | output | 1 | Data driven onto the line during reads |
| mdio_oe | output | 1 | Output enable for the data line driver |
| reg_valid | output | 1 | One-cycle register access strobe |
| reg_write | output | 1 | 1 for a write access, 0 for a read access |
| reg_addr | output | 5 | Register number of the access |
| reg_wdata | output | 16 | Write data of a write access |
| reg_rdata | input | 16 | Read data from the register file for `reg_addr` |

## Verification
Write-then-read pairs with distinct data words (alternating, all-ones, single low bit, mixed) separate a correct most-significant-first shift from a reversed or off-by-one one, and pairing different device addresses on the write and the read of the same register shows the device field is ignored. Long runs of 0 before the start 1 and turnaround bits of every value tell the start-wait and turnaround skipping apart from a decoder that counts them as data. Frames with the two unused opcodes, followed by a normal read and a final strobe count, distinguish a clean return to idle from a stray access or a hung decoder, and the output enable is watched during headers and after the last read bit.

// File: rtl/mgmt_frame_pkg.sv
package mgmt_frame_pkg;

    // Field widths of a management frame
    localparam int OPC_W      = 2;
    localparam int PHYA_W     = 5;
    localparam int REGA_W     = 5;
    localparam int WORD_W     = 16;
    localparam int WR_TA_BITS = 2;

    // Opcode encodings (decoded by the frame sequencer)
    localparam logic [OPC_W-1:0] OPC_READ  = 2'b10;
    localparam logic [OPC_W-1:0] OPC_WRITE = 2'b01;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_HDR,
        FS_TA_RD,
        FS_RD_DATA,
        FS_TA_WR,
        FS_WR_DATA
    } frame_state_e;

endpackage

// File: rtl/mgmt_sync.sv
module mgmt_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign chain_d[s] = d;
            end else begin : g_next
                assign chain_d[s] = chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mgmt_rise_det.sv
module mgmt_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
    import mgmt_frame_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int ADDR_W = REGA_W,
    parameter int PHY_W  = PHYA_W,
    parameter int OP_W   = OPC_W,
    parameter int TA_W   = WR_TA_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bit_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic              out_bit,
    output logic              out_en,
    output logic              acc_valid,
    output logic              acc_write,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata
);
    localparam int HDR_W = OP_W + PHY_W + ADDR_W;
    localparam int ACC_W = (DATA_W > HDR_W) ? DATA_W : HDR_W;
    localparam int CNT_W = $clog2(ACC_W + 1);

    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_TA   = CNT_W'(TA_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        frame_state_e      st;
        logic [CNT_W-1:0]  cnt;
        logic [ACC_W-1:0]  acc;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] shreg;
        logic              strobe;
        logic              strobe_wr;
        logic [ADDR_W-1:0] s_addr;
        logic [DATA_W-1:0] s_wdata;
    } fsm_t;

    fsm_t r_d, r_q;

    logic [ACC_W-1:0]  acc_next;
    logic [OP_W-1:0]   opcode;
    logic [ADDR_W-1:0] hdr_reg;
    logic              last_bit;

    always_comb begin
        acc_next = {r_q.acc[ACC_W-2:0], bit_in};
        opcode   = acc_next[HDR_W-1 -: OP_W];
        hdr_reg  = acc_next[ADDR_W-1:0];
        last_bit = (r_q.cnt == CNT_ONE);

        r_d           = r_q;
        r_d.strobe    = 1'b0;
        r_d.strobe_wr = 1'b0;

        // Read data is taken the cycle after the read strobe
        if (r_q.strobe && !r_q.strobe_wr) begin
            r_d.shreg = rd_data;
        end

        if (tick) begin
            unique case (r_q.st)
                FS_IDLE: begin
                    if (!bit_in) begin
                        r_d.st = FS_START;
                    end
                end
                FS_START: begin
                    if (bit_in) begin
                        r_d.st  = FS_HDR;
                        r_d.cnt = CNT_HDR;
                        r_d.acc = '0;
                    end
                end
                FS_HDR: begin
                    r_d.acc = acc_next;
                    r_d.cnt = r_q.cnt - CNT_ONE;
                    if (last_bit) begin
                        if (opcode == OPC_READ) begin
                            r_d.st        = FS_TA_RD;
                            r_d.strobe    = 1'b1;
                            r_d.strobe_wr = 1'b0;
                            r_d.s_addr    = hdr_reg;
                        end else if (opcode == OPC_WRITE) begin
                            r_d.st      = FS_TA_WR;
                            r_d.wr_addr = hdr_reg;
                            r_d.cnt     = CNT_TA;
                        end else begin
                            r_d.st = FS_IDLE;
                        end
                    end
                end
                FS_TA_RD: begin
                    r_d.st  = FS_RD_DATA;
                    r_d.cnt = CNT_DATA;
                end
                FS_RD_DATA: begin
                    r_d.shreg = {r_q.shreg[DATA_W-2:0], 1'b0};
                    r_d.cnt   = r_q.cnt - CNT_ONE;
                    if (last_bit) begin
                        r_d.st = FS_IDLE;
                    end
                end
                FS_TA_WR: begin
                    r_d.cnt = r_q.cnt - CNT_ONE;
                    if (last_bit) begin
                        r_d.st  = FS_WR_DATA;
                        r_d.cnt = CNT_DATA;
                    end
                end
                FS_WR_DATA: begin
                    r_d.acc = acc_next;
                    r_d.cnt = r_q.cnt - CNT_ONE;
                    if (last_bit) begin
                        r_d.st        = FS_IDLE;
                        r_d.strobe    = 1'b1;
                        r_d.strobe_wr = 1'b1;
                        r_d.s_addr    = r_q.wr_addr;
                        r_d.s_wdata   = acc_next[DATA_W-1:0];
                    end
                end
                default: begin
                    r_d.st = FS_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: FS_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign out_en    = (r_q.st == FS_TA_RD) || (r_q.st == FS_RD_DATA);
    assign out_bit   = (r_q.st == FS_RD_DATA) ? r_q.shreg[DATA_W-1] : 1'b0;
    assign acc_valid = r_q.strobe;
    assign acc_write = r_q.strobe_wr;
    assign acc_addr  = r_q.s_addr;
    assign acc_wdata = r_q.s_wdata;
endmodule

// File: rtl/mgmt_frame_slave.sv
module mgmt_frame_slave
    import mgmt_frame_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = WORD_W,
    parameter int ADDR_W      = REGA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc_in,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              reg_valid,
    output logic              reg_write,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic mdc_s, mdio_s, bit_tick;

    mgmt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_sync_mdc (
        .clk(clk), .rst_n(rst_n), .d(mdc_in), .q(mdc_s)
    );

    // Idle line level is 1
    mgmt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync_mdio (
        .clk(clk), .rst_n(rst_n), .d(mdio_in), .q(mdio_s)
    );

    mgmt_rise_det i_rise (
        .clk(clk), .rst_n(rst_n), .level(mdc_s), .rise(bit_tick)
    );

    mgmt_frame_fsm #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .PHY_W (PHYA_W),
        .OP_W  (OPC_W),
        .TA_W  (WR_TA_BITS)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_tick),
        .bit_in   (mdio_s),
        .rd_data  (reg_rdata),
        .out_bit  (mdio_out),
        .out_en   (mdio_oe),
        .acc_valid(reg_valid),
        .acc_write(reg_write),
        .acc_addr (reg_addr),
        .acc_wdata(reg_wdata)
    );
endmodule

// File: rtl/mgmt_frame_slave_chk.sv
module mgmt_frame_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic mdio_out,
    input logic mdio_oe,
    input logic reg_valid,
    input logic reg_write
);
    // R8: line data stays low while the driver is off
    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_oe |-> !mdio_out);

    // R8: no drive while a write is being committed
    a_r8_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write) |-> !mdio_oe);

    // R10: strobe is a single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid |=> !reg_valid);

    // R4: a read strobe coincides with the start of the read drive window
    a_r4_read_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write) |-> mdio_oe);

    // R5: the first driven bit is the low turnaround bit
    a_r5_ta_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    // R5: drive window opens with a read strobe
    a_r5_open_with_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> (reg_valid && !reg_write));
endmodule

bind mgmt_frame_slave mgmt_frame_slave_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .reg_valid(reg_valid),
    .reg_write(reg_write)
);

// File: tb/test_mgmt_frame_slave.sv
module test_mgmt_frame_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc_in = 1'b0;
    logic        mdio_in = 1'b1;
    logic        mdio_out, mdio_oe;
    logic        reg_valid, reg_write;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;

    always #2.5 clk = ~clk;

    mgmt_frame_slave i_mgmt_frame_slave (
        .clk(clk), .rst_n(rst_n), .mdc_in(mdc_in), .mdio_in(mdio_in),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Attached register file model and independent shadow of expected contents
    logic [15:0] rf [32];
    logic [15:0] shadow [32];
    assign reg_rdata = rf[reg_addr];

    int n_checks = 0;
    int n_fail = 0;
    int n_strobes = 0;
    int exp_strobes = 0;
    bit oe_seen = 0;

    logic [21:0] exp_q [$];

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: register writes and scoreboard comparison
    always @(negedge clk) begin
        if (rst_n && reg_valid) begin
            logic [21:0] e;
            n_strobes++;
            if (reg_write) rf[reg_addr] <= reg_wdata;
            if (exp_q.size() == 0) begin
                check("R7", "unexpected strobe", {10'd0, reg_write, reg_addr, reg_wdata}, 32'hFFFF_FFFF);
            end else begin
                e = exp_q.pop_front();
                check(e[21] ? "R6" : "R4", "strobe write flag", {31'd0, reg_write}, {31'd0, e[21]});
                check(e[21] ? "R6" : "R4", "strobe address", {27'd0, reg_addr}, {27'd0, e[20:16]});
                if (e[21]) check("R6", "write data", {16'd0, reg_wdata}, {16'd0, e[15:0]});
            end
            @(negedge clk);
            check("R10", "strobe length", {31'd0, reg_valid}, 32'd0);
        end
    end

    // One management clock period: drive data, low half, rising edge, high half
    task automatic send_bit(input logic b);
        @(negedge clk);
        mdio_in = b;
        mdc_in = 1'b0;
        repeat (4) @(negedge clk);
        if (mdio_oe) oe_seen = 1;
        mdc_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_header(input int zeros, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        for (int i = 0; i < zeros; i++) send_bit(1'b0);
        send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 4; i >= 0; i--) send_bit(phy[i]);
        for (int i = 4; i >= 0; i--) send_bit(rg[i]);
    endtask

    task automatic do_write(input int zeros, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] data, input logic [1:0] ta);
        exp_q.push_back({1'b1, rg, data});
        exp_strobes++;
        shadow[rg] = data;
        oe_seen = 0;
        send_header(zeros, 2'b01, phy, rg);
        send_bit(ta[1]);
        send_bit(ta[0]);
        for (int i = 15; i >= 0; i--) send_bit(data[i]);
        send_bit(1'b1);
        check("R8", "oe during write frame", {31'd0, oe_seen}, 32'd0);
    endtask

    task automatic do_read(input int zeros, input logic [4:0] phy, input logic [4:0] rg);
        logic [15:0] got;
        logic ta_ok;
        exp_q.push_back({1'b0, rg, 16'd0});
        exp_strobes++;
        oe_seen = 0;
        send_header(zeros, 2'b10, phy, rg);
        check("R8", "oe during read header", {31'd0, oe_seen}, 32'd0);
        // Turnaround slot
        @(negedge clk);
        mdio_in = 1'b1;
        mdc_in = 1'b0;
        repeat (4) @(negedge clk);
        ta_ok = mdio_oe && !mdio_out;
        mdc_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R5", "turnaround driven low", {31'd0, ta_ok}, 32'd1);
        got = '0;
        for (int i = 15; i >= 0; i--) begin
            mdc_in = 1'b0;
            repeat (4) @(negedge clk);
            got[i] = mdio_oe ? mdio_out : 1'bx;
            mdc_in = 1'b1;
            repeat (4) @(negedge clk);
        end
        check("R5", $sformatf("read data reg %0d", rg), {16'd0, got}, {16'd0, shadow[rg]});
        oe_seen = 0;
        send_bit(1'b1);
        send_bit(1'b1);
        check("R8", "oe released after read", {31'd0, oe_seen}, 32'd0);
    endtask

    task automatic do_illegal(input logic [1:0] op, input logic [4:0] rg);
        oe_seen = 0;
        send_header(1, op, 5'd0, rg);
        for (int i = 0; i < 20; i++) send_bit(1'b1);
        check("R7", $sformatf("oe after opcode %b", op), {31'd0, oe_seen}, 32'd0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            rf[i] = 16'(i * 16'h0101) ^ 16'h5A00;
            shadow[i] = 16'(i * 16'h0101) ^ 16'h5A00;
        end
        repeat (5) @(negedge clk);
        // R9: reset state
        check("R9", "oe in reset", {31'd0, mdio_oe}, 32'd0);
        check("R9", "out in reset", {31'd0, mdio_out}, 32'd0);
        check("R9", "strobe in reset", {31'd0, reg_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9", "oe after reset", {31'd0, mdio_oe}, 32'd0);

        // R2 R6: basic write then read, R5 MSB-first return
        do_write(1, 5'd0, 5'd3, 16'hA5C3, 2'b10);
        do_read(1, 5'd0, 5'd3);
        // R3: different device addresses on write and read; R6 TA bits 11 ignored
        do_write(1, 5'd17, 5'd31, 16'h0001, 2'b11);
        do_read(1, 5'd9, 5'd31);
        // R1: extra zeros before start; R6 TA bits 00 ignored
        do_write(3, 5'd31, 5'd0, 16'hFFFF, 2'b00);
        do_read(2, 5'd4, 5'd0);
        // R4: untouched register holds its initial contents
        do_read(1, 5'd0, 5'd5);
        do_write(1, 5'd2, 5'd18, 16'hFFFE, 2'b01);
        do_read(1, 5'd2, 5'd18);
        // R7: unused opcodes
        do_illegal(2'b00, 5'd0);
        do_illegal(2'b11, 5'd0);
        do_read(1, 5'd0, 5'd0);
        check("R7", "register 0 kept after unused opcodes", {16'd0, rf[0]}, 32'h0000_FFFF);

        repeat (10) @(negedge clk);
        check("R7", "total strobes", n_strobes, exp_strobes);
        check("R4", "scoreboard drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule